// File: doc/BRIEF.md
# MSI Doorbell Receive Engine

This block sits on the inbound posted-write path of a PCIe root port. Each incoming write request (valid, address, data) is compared with a programmed MSI capture address. A write that hits that address is an MSI. The block absorbs it: it is never handed to the system-side write port. The low byte of its payload picks one of 256 doorbells, laid out as banks of 32 bits, and that doorbell's status bit is latched. Every other write leaves on the system side unchanged.

Each bank has three registers: a status register that software clears by writing 1s, an enable register that decides which doorbells may latch at all, and a mask register that keeps latched bits from raising the interrupt. The single interrupt output is the OR over all banks of status bits that are set and not masked. A small register port programs the capture address, the enable and mask registers, and the status clears, and reads any of them back combinationally.

Register selector `cfg_addr_i` = {kind[1:0], bank[2:0]}. The kinds are: 0 status (write 1 to clear), 1 enable, 2 mask (1 = masked), 3 capture address. For kind 3, bank bit 0 picks the half: 0 is the low 32 bits and 1 is the high 32 bits.

Top module: `msi_doorbell_engine`

## Requirements
- R1: A valid inbound write whose 64-bit address equals the capture address is absorbed: `out_valid_o` stays low in that cycle. Any other valid write appears on `out_valid_o`/`out_addr_o`/`out_data_o` in the same cycle, with address and data unchanged.
- R2: The capture address is written in two 32-bit halves (kind 3; bank bit 0 = 0 for the low half, 1 for the high half). Its bits [1:0] always read 0, so a write to an address with nonzero bits [1:0] is never absorbed.
- R3: For an absorbed write, data bits [7:5] select the bank and data bits [4:0] select the bit. That status bit reads 1 from the cycle after the write.
- R4: Data bits above bit 7 of an absorbed write have no effect on which doorbell is set.
- R5: An absorbed write aimed at a doorbell whose enable bit is 0 sets no status bit and is still absorbed.
- R6: `irq_o` is high exactly when some bank has a status bit that is 1 while its mask bit is 0. It follows status and mask changes one cycle after the causing write.
- R7: A status-kind register write clears the status bits where the write data is 1 and leaves the other bits alone, from the next cycle on.
- R8: When a doorbell is set and cleared in the same cycle, the bit stays set.
- R9: After reset, all status, enable, mask and capture registers read 0 and `irq_o` is low.
- R10: Enable and mask registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Inbound write request valid |
| in_addr_i | input | 64 | Inbound write target address |
| in_data_i | input | 32 | Inbound write payload |
| out_valid_o | output | 1 | Forwarded write valid (system side) |
| out_addr_o | output | 64 | Forwarded write address |
| out_data_o | output | 32 | Forwarded write payload |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register selector {kind, bank} |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` |
| irq_o | output | 1 | Combined doorbell interrupt |

## Verification
Forwarding is combinational, so the absorb-or-pass decision is due in the same cycle as the inbound write. Status, enable, mask and capture changes become visible on `cfg_rdata_o` and `irq_o` one cycle after the write that causes them. The bench drives inputs at the falling edge and samples every output a quarter period later, before the rising edge. It compares each output with a behavioural model, and the model applies a write only at the rising edge that follows it. Together these keep every check aligned with the cycle in which its result is due.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;

   typedef enum logic [1:0] {
      KIND_STATUS  = 2'd0,
      KIND_ENABLE  = 2'd1,
      KIND_MASK    = 2'd2,
      KIND_CAPTURE = 2'd3
   } reg_kind_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/msi_capture_match.sv
module msi_capture_match #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned HALF_W  = 32,
   parameter bit          FWD_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cap_we_lo_i,
   input  logic              cap_we_hi_i,
   input  logic [HALF_W-1:0] cap_wdata_i,
   input  logic              in_valid_i,
   input  logic [ADDR_W-1:0] in_addr_i,
   input  logic [DATA_W-1:0] in_data_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] cap_addr_o,
   output logic              out_valid_o,
   output logic [ADDR_W-1:0] out_addr_o,
   output logic [DATA_W-1:0] out_data_o
);

   localparam logic [HALF_W-1:0] ALIGN_MASK = ~HALF_W'(3);

   if (ADDR_W != 2 * HALF_W) begin : g_bad_split
      $error("capture address must be exactly two register halves");
   end

   logic [ADDR_W-1:0] cap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cap_q <= '0;
      end else begin
         if (cap_we_lo_i) cap_q[HALF_W-1:0]      <= cap_wdata_i & ALIGN_MASK;
         if (cap_we_hi_i) cap_q[ADDR_W-1:HALF_W] <= cap_wdata_i;
      end
   end

   assign cap_addr_o = cap_q;
   assign hit_o      = in_valid_i && (in_addr_i == cap_q);

   if (FWD_REG) begin : g_fwd_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            out_valid_o <= 1'b0;
            out_addr_o  <= '0;
            out_data_o  <= '0;
         end else begin
            out_valid_o <= in_valid_i && !hit_o;
            out_addr_o  <= in_addr_i;
            out_data_o  <= in_data_i;
         end
      end
   end else begin : g_fwd_comb
      assign out_valid_o = in_valid_i && !hit_o;
      assign out_addr_o  = in_addr_i;
      assign out_data_o  = in_data_i;
   end

   // R2: only dword-aligned targets can ever be captured
   p_aligned_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> (in_addr_i[1:0] == 2'b00));

endmodule

// File: rtl/msi_doorbell_bank.sv
module msi_doorbell_bank #(
   parameter int unsigned BANK_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [BANK_W-1:0] set_i,
   input  logic              clr_we_i,
   input  logic              en_we_i,
   input  logic              mask_we_i,
   input  logic [BANK_W-1:0] wdata_i,
   output logic [BANK_W-1:0] status_o,
   output logic [BANK_W-1:0] en_o,
   output logic [BANK_W-1:0] mask_o,
   output logic              irq_o
);

   logic [BANK_W-1:0] status_q, en_q, mask_q;
   logic [BANK_W-1:0] set_ok, clr_vec, status_d;

   assign set_ok   = set_i & en_q;
   assign clr_vec  = clr_we_i ? wdata_i : '0;
   // a doorbell arriving together with its clear wins
   assign status_d = (status_q & ~clr_vec) | set_ok;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         status_q <= '0;
         en_q     <= '0;
         mask_q   <= '0;
      end else begin
         status_q <= status_d;
         if (en_we_i)   en_q   <= wdata_i;
         if (mask_we_i) mask_q <= wdata_i;
      end
   end

   assign status_o = status_q;
   assign en_o     = en_q;
   assign mask_o   = mask_q;
   assign irq_o    = |(status_q & ~mask_q);

   // R8: an accepted doorbell is visible next cycle even under a clear
   p_set_sticks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(set_i & en_q)) |=> ((status_q & $past(set_i & en_q)) == $past(set_i & en_q)));

   // R5: a status bit can only rise from an enabled doorbell
   p_drop_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(status_q) |-> ((status_q & ~$past(status_q) & ~$past(set_i & en_q)) == '0));

   // R7: a clear with no competing doorbell empties the written bits
   p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && !(|(set_i & en_q))) |=> ((status_q & $past(wdata_i)) == '0));

endmodule

// File: rtl/msi_doorbell_engine.sv
module msi_doorbell_engine
   import msi_db_pkg::*;
#(
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned BANK_W    = 32,
   parameter bit          FWD_REG   = 1'b0,
   localparam int unsigned BANK_IDX_W = $clog2(NUM_BANKS),
   localparam int unsigned BIT_IDX_W  = $clog2(BANK_W),
   localparam int unsigned CFG_AW     = 2 + BANK_IDX_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   input  logic [ADDR_W-1:0] in_addr_i,
   input  logic [DATA_W-1:0] in_data_i,
   output logic              out_valid_o,
   output logic [ADDR_W-1:0] out_addr_o,
   output logic [DATA_W-1:0] out_data_o,
   input  logic              cfg_we_i,
   input  logic [CFG_AW-1:0] cfg_addr_i,
   input  logic [BANK_W-1:0] cfg_wdata_i,
   output logic [BANK_W-1:0] cfg_rdata_o,
   output logic              irq_o
);

   if (NUM_BANKS < 2 || !is_pow2(NUM_BANKS)) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (!is_pow2(BANK_W)) begin : g_bad_bank_w
      $error("BANK_W must be a power of two");
   end
   if (BANK_IDX_W + BIT_IDX_W > DATA_W) begin : g_bad_decode
      $error("doorbell index does not fit in the MSI payload");
   end

   reg_kind_e             cfg_kind;
   logic [BANK_IDX_W-1:0] cfg_bank;
   logic                  msi_hit;
   logic [ADDR_W-1:0]     cap_addr;
   logic [BANK_IDX_W-1:0] msi_bank;
   logic [BIT_IDX_W-1:0]  msi_bit;
   logic [BANK_W-1:0]     msi_onehot;
   logic [BANK_W-1:0]     bank_status [NUM_BANKS];
   logic [BANK_W-1:0]     bank_en     [NUM_BANKS];
   logic [BANK_W-1:0]     bank_mask   [NUM_BANKS];
   logic [NUM_BANKS-1:0]  bank_irq;

   assign cfg_kind = reg_kind_e'(cfg_addr_i[CFG_AW-1 -: 2]);
   assign cfg_bank = cfg_addr_i[BANK_IDX_W-1:0];

   msi_capture_match #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .HALF_W  (BANK_W),
      .FWD_REG (FWD_REG)
   ) u_match (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cap_we_lo_i (cfg_we_i && cfg_kind == KIND_CAPTURE && !cfg_bank[0]),
      .cap_we_hi_i (cfg_we_i && cfg_kind == KIND_CAPTURE &&  cfg_bank[0]),
      .cap_wdata_i (cfg_wdata_i),
      .in_valid_i  (in_valid_i),
      .in_addr_i   (in_addr_i),
      .in_data_i   (in_data_i),
      .hit_o       (msi_hit),
      .cap_addr_o  (cap_addr),
      .out_valid_o (out_valid_o),
      .out_addr_o  (out_addr_o),
      .out_data_o  (out_data_o)
   );

   // payload decode: bank above the bit index, upper payload bits unused
   assign msi_bank = in_data_i[BIT_IDX_W +: BANK_IDX_W];
   assign msi_bit  = in_data_i[BIT_IDX_W-1:0];

   always_comb begin
      msi_onehot          = '0;
      msi_onehot[msi_bit] = 1'b1;
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel_cfg;
      assign sel_cfg = cfg_we_i && (cfg_bank == BANK_IDX_W'(b));

      msi_doorbell_bank #(
         .BANK_W (BANK_W)
      ) u_bank (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .set_i     ((msi_hit && msi_bank == BANK_IDX_W'(b)) ? msi_onehot : '0),
         .clr_we_i  (sel_cfg && cfg_kind == KIND_STATUS),
         .en_we_i   (sel_cfg && cfg_kind == KIND_ENABLE),
         .mask_we_i (sel_cfg && cfg_kind == KIND_MASK),
         .wdata_i   (cfg_wdata_i),
         .status_o  (bank_status[b]),
         .en_o      (bank_en[b]),
         .mask_o    (bank_mask[b]),
         .irq_o     (bank_irq[b])
      );
   end

   always_comb begin
      unique case (cfg_kind)
         KIND_STATUS:  cfg_rdata_o = bank_status[cfg_bank];
         KIND_ENABLE:  cfg_rdata_o = bank_en[cfg_bank];
         KIND_MASK:    cfg_rdata_o = bank_mask[cfg_bank];
         KIND_CAPTURE: cfg_rdata_o = cfg_bank[0] ? cap_addr[ADDR_W-1:BANK_W]
                                                 : cap_addr[BANK_W-1:0];
         default:      cfg_rdata_o = '0;
      endcase
   end

   assign irq_o = |bank_irq;

   // R6: the interrupt can only rise after a captured doorbell or a mask change
   p_irq_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(msi_hit || (cfg_we_i && cfg_kind == KIND_MASK)));

   if (!FWD_REG) begin : g_fwd_chk
      // R1: a write that misses the capture address leaves in the same cycle
      p_forward_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (in_valid_i && in_addr_i != cap_addr) |->
            (out_valid_o && out_addr_o == in_addr_i && out_data_o == in_data_i));
   end

endmodule

// File: tb/msi_doorbell_engine_bench.sv
module msi_doorbell_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_addr = '0;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic [63:0] out_addr;
   logic [31:0] out_data;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // reference model state
   logic [31:0] m_status [8];
   logic [31:0] m_en     [8];
   logic [31:0] m_mask   [8];
   logic [63:0] m_cap;

   always #10 clk = ~clk;

   msi_doorbell_engine u_msi_doorbell_engine (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .in_valid_i  (in_valid),
      .in_addr_i   (in_addr),
      .in_data_i   (in_data),
      .out_valid_o (out_valid),
      .out_addr_o  (out_addr),
      .out_data_o  (out_data),
      .cfg_we_i    (cfg_we),
      .cfg_addr_i  (cfg_addr),
      .cfg_wdata_i (cfg_wdata),
      .cfg_rdata_o (cfg_rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [4:0] ra(input int kind, input int bank);
      return {2'(kind), 3'(bank)};
   endfunction

   // compare all outputs with the model, then advance one clock
   task automatic step(input string tag);
      logic        hit;
      logic        exp_irq;
      logic [31:0] exp_rd;
      logic [31:0] nst [8];
      int          k, b;
      #5;
      hit = in_valid && (in_addr == m_cap);
      chk("R1", "out_valid", 64'(out_valid), 64'(in_valid && !hit));
      if (in_valid && !hit) begin
         chk("R1", "out_addr", out_addr, in_addr);
         chk("R1", "out_data", 64'(out_data), 64'(in_data));
      end
      exp_irq = 1'b0;
      for (int i = 0; i < 8; i++) if ((m_status[i] & ~m_mask[i]) != 0) exp_irq = 1'b1;
      chk("R6", "irq", 64'(irq), 64'(exp_irq));
      k = int'(cfg_addr[4:3]);
      b = int'(cfg_addr[2:0]);
      case (k)
         0: exp_rd = m_status[b];
         1: exp_rd = m_en[b];
         2: exp_rd = m_mask[b];
         default: exp_rd = b[0] ? m_cap[63:32] : m_cap[31:0];
      endcase
      chk(tag, "rdata", 64'(cfg_rdata), 64'(exp_rd));
      @(posedge clk);
      for (int i = 0; i < 8; i++) nst[i] = m_status[i];
      if (cfg_we && k == 0) nst[b] = nst[b] & ~cfg_wdata;
      if (hit && m_en[in_data[7:5]][in_data[4:0]]) nst[in_data[7:5]][in_data[4:0]] = 1'b1;
      if (cfg_we && k == 1) m_en[b] = cfg_wdata;
      if (cfg_we && k == 2) m_mask[b] = cfg_wdata;
      if (cfg_we && k == 3) begin
         if (b[0]) m_cap[63:32] = cfg_wdata;
         else      m_cap[31:0]  = {cfg_wdata[31:2], 2'b00};
      end
      for (int i = 0; i < 8; i++) m_status[i] = nst[i];
      @(negedge clk);
   endtask

   task automatic idle();
      in_valid = 1'b0;
      cfg_we   = 1'b0;
   endtask

   task automatic cfg_wr(input logic [4:0] a, input logic [31:0] d, input string tag);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      step(tag);
      idle();
   endtask

   task automatic rd(input logic [4:0] a, input string tag);
      cfg_addr = a;
      step(tag);
   endtask

   task automatic wr_in(input logic [63:0] a, input logic [31:0] d, input string tag);
      in_valid = 1'b1; in_addr = a; in_data = d;
      step(tag);
      idle();
   endtask

   localparam logic [63:0] CAP = 64'h0000_00FE_E000_1000;

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_status[i] = '0; m_en[i] = '0; m_mask[i] = '0;
      end
      m_cap = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state of every register
      for (int k = 0; k < 4; k++)
         for (int b = 0; b < 8; b++) rd(ra(k, b), "R9");

      // R2: program the capture address; low two bits are forced to zero
      cfg_wr(ra(3, 0), 32'hE000_1003, "R2");
      cfg_wr(ra(3, 1), 32'h0000_00FE, "R2");
      rd(ra(3, 0), "R2");
      rd(ra(3, 1), "R2");

      // R1: writes that miss the capture address pass through unchanged
      wr_in(64'h0000_0000_8000_0000, 32'h1234_5678, "R1");
      wr_in(CAP ^ 64'h8000_0000_0000_0000, 32'h0000_0001, "R1");
      wr_in(CAP ^ 64'h0000_0000_0001_0000, 32'hDEAD_BEEF, "R1");
      // R2: an unaligned address next to the capture address is forwarded
      wr_in(CAP | 64'h3, 32'h0000_0000, "R2");
      wr_in(CAP | 64'h1, 32'h0000_00E5, "R2");

      // R10: enable and mask readback
      for (int b = 0; b < 8; b++) cfg_wr(ra(1, b), 32'hFFFF_FFFF, "R10");
      cfg_wr(ra(1, 2), 32'hFFFF_FFFE, "R10");
      cfg_wr(ra(2, 6), 32'hA5A5_5A5A, "R10");
      rd(ra(1, 2), "R10");
      rd(ra(2, 6), "R10");
      cfg_wr(ra(2, 6), 32'h0, "R10");

      // R3: bank in data[7:5], bit in data[4:0]
      cfg_addr = ra(0, 0);
      wr_in(CAP, 32'h0000_0000, "R3");
      rd(ra(0, 0), "R3");
      wr_in(CAP, 32'h0000_00E5, "R3");
      rd(ra(0, 7), "R3");
      // R4: upper payload bits ignored -> bank 1 bit 31
      wr_in(CAP, 32'hFFFF_FF3F, "R4");
      rd(ra(0, 1), "R4");
      wr_in(CAP, 32'h5A5A_0068, "R4");
      rd(ra(0, 3), "R4");

      // R5: disabled doorbell (bank 2 bit 0) is dropped but still absorbed
      wr_in(CAP, 32'h0000_0040, "R5");
      rd(ra(0, 2), "R5");
      wr_in(CAP, 32'h0000_0041, "R5");
      rd(ra(0, 2), "R5");

      // R7: clear everything, partly first
      cfg_wr(ra(0, 0), 32'h0000_0000, "R7");
      cfg_wr(ra(0, 7), 32'h0000_0020, "R7");
      rd(ra(0, 7), "R7");
      cfg_wr(ra(0, 1), 32'h7FFF_FFFF, "R7");
      rd(ra(0, 1), "R7");
      for (int b = 0; b < 8; b++) cfg_wr(ra(0, b), 32'hFFFF_FFFF, "R7");
      rd(ra(0, 1), "R7");

      // R6: masked bit keeps irq low, unmasking raises it
      cfg_wr(ra(2, 4), 32'h0000_0200, "R6");
      wr_in(CAP, 32'h0000_0089, "R6");
      rd(ra(0, 4), "R6");
      cfg_wr(ra(2, 4), 32'h0000_0000, "R6");
      rd(ra(0, 4), "R6");
      cfg_wr(ra(2, 4), 32'h0000_0200, "R6");
      rd(ra(0, 4), "R6");
      cfg_wr(ra(2, 4), 32'h0, "R6");

      // R8: same-cycle set and clear on bank 5 bit 3
      cfg_we = 1'b1; cfg_addr = ra(0, 5); cfg_wdata = 32'hFFFF_FFFF;
      in_valid = 1'b1; in_addr = CAP; in_data = 32'h0000_00A3;
      step("R8");
      idle();
      rd(ra(0, 5), "R8");
      cfg_we = 1'b1; cfg_addr = ra(0, 4); cfg_wdata = 32'hFFFF_FFFF;
      in_valid = 1'b1; in_addr = CAP; in_data = 32'h0000_0089;
      step("R8");
      idle();
      rd(ra(0, 4), "R8");
      for (int b = 0; b < 8; b++) cfg_wr(ra(0, b), 32'hFFFF_FFFF, "R7");

      // R3: sweep all 256 doorbells, reading the bank as it fills
      for (int v = 0; v < 256; v++) begin
         cfg_addr = ra(0, v / 32);
         wr_in(CAP, 32'(v), "R3");
      end
      for (int b = 0; b < 8; b++) rd(ra(0, b), "R3");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule